// File: doc/BRIEF.md
# TPM SPI Register Access Framer

This block is the host side of a single register access to a security device on a SPI bus. A request carries a direction, a byte count, a 24-bit register address and, for writes, the bytes to send. The block lowers chip select and sends a four-byte header with the direction, the length and the address. It then honours the target's wait-state flow control: the target can hold off the data phase by returning a low ready bit. After that it moves the data bytes, raises chip select and reports completion with an error flag.

If the target keeps stalling past a programmable limit, the access is abandoned and reported as an error. If the bus has been quiet long enough that the target may have gone to sleep, a short chip-select pulse and a settling gap come before the transaction. All time limits are counted in system clock cycles. The SPI clock comes from a simple divider: SPI mode 0, MSB first.

The request side is a valid/ready handshake. `req_ready` is high only when the block is idle and is not showing a completion. A request is taken on the cycle where both signals are high. No back-pressure exists on the result: `done` is a one-cycle pulse, and `rsp_rdata` holds its value until the next request is accepted.

Top module: `spi_reg_framer`

## Requirements
- R1: The first byte sent after chip select falls is the control byte: bit 7 is 1 for a read and 0 for a write, bit 6 is 1, and bits 5:0 hold the length minus one.
- R2: The next three bytes carry address bits 23:16, 15:8 and 7:0 in that order. Every byte is sent MSB first in SPI mode 0: the clock idles low, MOSI is stable while the clock is high, and MISO is sampled on the rising edge.
- R3: A request with a length of 0 or above MAX_BYTES is rejected. `done` and `err` are high in the cycle after acceptance, and chip select does not move.
- R4: From the first header bit to the last data byte, chip select stays low without a break. The number of bytes clocked is exactly 4 plus the wait bytes plus the length.
- R5: If bit 0 of the byte received during the fourth header byte is 1, the data phase follows at once, with no wait bytes.
- R6: If that bit is 0, the block clocks dummy bytes of 0x00 until a received byte has bit 0 set, and then starts the data phase.
- R7: If the wait phase lasts POLL_TIMEOUT cycles without a ready bit, chip select rises at the end of the current dummy byte. `done` and `err` then pulse together, and `rsp_rdata` reads all zero.
- R8: On a write, data byte i is taken from `req_wdata[8i+7:8i]`, with i increasing. On a read, the i-th received data byte is stored in `rsp_rdata[8i+7:8i]`.
- R9: When chip select has been high for at least IDLE_LIMIT cycles, or no access has happened since reset, the access begins with a wake pulse. Chip select goes low for WAKE_LOW cycles with no SPI clock, then stays high for WAKE_GAP cycles, and then the header starts.
- R10: `req_ready` is high only while idle and not in a `done` cycle. `done` lasts exactly one cycle, and `err` is low on a completed access.
- R11: The SPI clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_len | input | LEN_W | Byte count; 1 to MAX_BYTES is legal |
| req_addr | input | 24 | Register address |
| req_wdata | input | MAX_BYTES*8 | Write bytes; byte i in bits 8i+7:8i |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error, valid with `done` |
| rsp_rdata | output | MAX_BYTES*8 | Read bytes; byte i in bits 8i+7:8i |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host-to-target data |
| spi_miso | input | 1 | Target-to-host data |

## Verification
A wrong header index or length field appears on MOSI within the first four byte times, because the target model records every byte. A fault in the wait-state logic changes the total bit count or the position of the data bytes, and the read data comes back shifted, within the same access. A wrong poll timer or idle tracker is seen at the end of the access that uses it: the error flag arrives when it should not, or does not arrive when it should, or the number of chip-select falls and the measured pulse and gap lengths are wrong.

// File: rtl/spi_framer_pkg.sv
package spi_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE_LO,
    ST_WAKE_GAP,
    ST_HDR,
    ST_POLL,
    ST_DATA
  } fr_state_t;

  // control byte: direction, fixed marker, length minus one
  function automatic logic [7:0] ctrl_byte(input logic rd, input logic [5:0] len_m1);
    return {rd, 1'b1, len_m1};
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          active;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_sr;

  assign mosi = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      div_q     <= '0;
      bit_q     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      sclk      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        tx_sr  <= tx_byte;
        div_q  <= '0;
        bit_q  <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk  <= 1'b0;
            tx_sr <= {tx_sr[6:0], 1'b0};
            if (bit_q == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_idle_tracker.sv
module spi_idle_tracker #(
  parameter int IDLE_LIMIT = 45_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic expired
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] cnt_q;

  // starts saturated so the first access after reset wakes the target
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= LIM;
    else if (!cs_n)           cnt_q <= '0;
    else if (cnt_q != LIM)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM);
endmodule

// File: rtl/spi_reg_framer.sv
module spi_reg_framer
  import spi_framer_pkg::*;
#(
  parameter int MAX_BYTES    = 64,
  parameter int HALF_DIV     = 2,
  parameter int POLL_TIMEOUT = 5_000_000,
  parameter int IDLE_LIMIT   = 45_000_000,
  parameter int WAKE_LOW     = 50,
  parameter int WAKE_GAP     = 5_000,
  localparam int LEN_W       = $clog2(MAX_BYTES) + 1,
  localparam int DATA_W      = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [23:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int PW    = $clog2(POLL_TIMEOUT + 1);
  localparam int WMAX  = (WAKE_LOW > WAKE_GAP) ? WAKE_LOW : WAKE_GAP;
  localparam int WW    = $clog2(WMAX + 1);
  localparam logic [PW-1:0] POLL_LIM = PW'(POLL_TIMEOUT);
  localparam logic [WW-1:0] WLO_LAST = WW'(WAKE_LOW - 1);
  localparam logic [WW-1:0] WGP_LAST = WW'(WAKE_GAP - 1);

  fr_state_t         st_q;
  logic              cs_n_q, kick_q, rd_q, done_q, err_q;
  logic [IDX_W-1:0]  lenm1_q, didx_q;
  logic [1:0]        hidx_q;
  logic [23:0]       addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [7:0]        rbuf [MAX_BYTES];
  logic [7:0]        wbuf [MAX_BYTES];
  logic [PW-1:0]     poll_q;
  logic [WW-1:0]     wcnt_q;
  logic [7:0]        tx_byte, rx_byte;
  logic              byte_done, wake_need, len_bad;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bytes
    assign wbuf[g]             = wdata_q[8*g +: 8];
    assign rsp_rdata[8*g +: 8] = rbuf[g];
  end

  assign req_ready = (st_q == ST_IDLE) && !done_q;
  assign done      = done_q;
  assign err       = err_q;
  assign spi_cs_n  = cs_n_q;
  assign len_bad   = (req_len == '0) || (req_len > LEN_W'(MAX_BYTES));

  always_comb begin
    tx_byte = 8'h00;
    if (st_q == ST_HDR) begin
      case (hidx_q)
        2'd0:    tx_byte = ctrl_byte(rd_q, 6'(lenm1_q));
        2'd1:    tx_byte = addr_q[23:16];
        2'd2:    tx_byte = addr_q[15:8];
        default: tx_byte = addr_q[7:0];
      endcase
    end else if (st_q == ST_DATA && !rd_q) begin
      tx_byte = wbuf[didx_q];
    end
  end

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(kick_q), .tx_byte(tx_byte),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx_byte(rx_byte), .byte_done(byte_done)
  );

  spi_idle_tracker #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n_q), .expired(wake_need)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      kick_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      lenm1_q <= '0;
      didx_q  <= '0;
      hidx_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      poll_q  <= '0;
      wcnt_q  <= '0;
      for (int i = 0; i < MAX_BYTES; i++) rbuf[i] <= '0;
    end else begin
      kick_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid && req_ready) begin
          if (len_bad) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            rd_q    <= req_read;
            lenm1_q <= IDX_W'(req_len - 1'b1);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            for (int i = 0; i < MAX_BYTES; i++) rbuf[i] <= '0;
            cs_n_q  <= 1'b0;
            hidx_q  <= '0;
            wcnt_q  <= '0;
            if (wake_need) st_q <= ST_WAKE_LO;
            else begin
              st_q   <= ST_HDR;
              kick_q <= 1'b1;
            end
          end
        end
        ST_WAKE_LO: begin
          if (wcnt_q == WLO_LAST) begin
            cs_n_q <= 1'b1;
            wcnt_q <= '0;
            st_q   <= ST_WAKE_GAP;
          end else wcnt_q <= wcnt_q + 1'b1;
        end
        ST_WAKE_GAP: begin
          if (wcnt_q == WGP_LAST) begin
            cs_n_q <= 1'b0;
            kick_q <= 1'b1;
            st_q   <= ST_HDR;
          end else wcnt_q <= wcnt_q + 1'b1;
        end
        ST_HDR: if (byte_done) begin
          kick_q <= 1'b1;
          if (hidx_q == 2'd3) begin
            didx_q <= '0;
            poll_q <= '0;
            st_q   <= rx_byte[0] ? ST_DATA : ST_POLL;
          end else hidx_q <= hidx_q + 2'd1;
        end
        ST_POLL: begin
          if (poll_q != POLL_LIM) poll_q <= poll_q + 1'b1;
          if (byte_done) begin
            if (rx_byte[0]) begin
              kick_q <= 1'b1;
              st_q   <= ST_DATA;
            end else if (poll_q >= POLL_LIM) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              err_q  <= 1'b1;
              for (int i = 0; i < MAX_BYTES; i++) rbuf[i] <= '0;
              st_q   <= ST_IDLE;
            end else kick_q <= 1'b1;
          end
        end
        ST_DATA: if (byte_done) begin
          if (rd_q) rbuf[didx_q] <= rx_byte;
          if (didx_q == lenm1_q) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            didx_q <= didx_q + 1'b1;
            kick_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_framer_chk.sv
module spi_reg_framer_chk
  import spi_framer_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int LEN_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             done,
  input logic             err,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input fr_state_t        st
);
  assert_sclk_low_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_reject_bad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0 || req_len > LEN_W'(MAX_BYTES)))
      |=> (done && err && spi_cs_n));

  assert_cs_no_early_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (done || st == ST_WAKE_GAP));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_only_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

  assert_wake_no_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE_LO || st == ST_WAKE_GAP) |-> !spi_sclk);
endmodule

bind spi_reg_framer spi_reg_framer_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .done(done), .err(err), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .st(st_q)
);

// File: tb/tb_spi_reg_framer.sv
module tb_spi_reg_framer;
  localparam int MAXB = 64, HALF = 2, TMO = 400, IDLE = 3000, WLO = 5, WGAP = 20;
  localparam int LW = $clog2(MAXB) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic req_ready, done, err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [LW-1:0] req_len = '0;
  logic [23:0] req_addr = '0;
  logic [MAXB*8-1:0] req_wdata = '0, rsp_rdata;

  always #10 clk = ~clk;

  spi_reg_framer #(.MAX_BYTES(MAXB), .HALF_DIV(HALF), .POLL_TIMEOUT(TMO),
    .IDLE_LIMIT(IDLE), .WAKE_LOW(WLO), .WAKE_GAP(WGAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_len(req_len), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .err(err), .rsp_rdata(rsp_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // target model
  int dev_wait = 0;
  logic [7:0] dev_rd [MAXB];
  logic [7:0] got [256];
  int nbits = 0, bad_sclk = 0, ncsf = 0, busy_ready = 0;
  logic [7:0] sh = '0, cur_out;

  function automatic logic [7:0] dev_byte(input int b);
    int rdy = 3 + dev_wait;
    if (b < rdy) return 8'hFE;
    if (b == rdy) return 8'h01;
    if (b - rdy - 1 < MAXB) return dev_rd[b - rdy - 1];
    return 8'h00;
  endfunction

  always_comb begin
    cur_out  = dev_byte(nbits / 8);
    spi_miso = spi_cs_n ? 1'b0 : cur_out[7 - (nbits % 8)];
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n) bad_sclk++;
    else begin
      sh = {sh[6:0], spi_mosi};
      nbits++;
      if (nbits % 8 == 0 && nbits / 8 <= 256) got[nbits/8 - 1] = sh;
    end
  end

  always @(negedge spi_cs_n) ncsf++;

  int lowrun = 0, highrun = 0, nseg = 0;
  int seg_low [8];
  int seg_gap [8];
  always @(negedge clk) begin
    if (!spi_cs_n) begin
      if (lowrun == 0 && nseg > 0 && nseg < 8) seg_gap[nseg] = highrun;
      lowrun++;
      highrun = 0;
      if (req_ready) busy_ready++;
    end else begin
      if (lowrun > 0) begin
        if (nseg < 8) seg_low[nseg] = lowrun;
        nseg++;
        lowrun = 0;
      end
      highrun++;
    end
  end

  function automatic logic [7:0] exp_ctrl(input bit rd, input int len);
    return {rd, 1'b1, 6'(len - 1)};
  endfunction

  task automatic clear_mon();
    nbits = 0; bad_sclk = 0; ncsf = 0; busy_ready = 0; nseg = 0; lowrun = 0;
    for (int i = 0; i < 256; i++) got[i] = 8'h00;
  endtask

  task automatic issue(input bit rd, input int len, input logic [23:0] addr);
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_read = rd; req_len = LW'(len); req_addr = addr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(input bit rd, input int len, input logic [23:0] addr, input int wn,
                     input bit exp_wake, input bit exp_to);
    int cyc = 0, bad = 0;
    logic e;
    logic [MAXB*8-1:0] rdat;
    dev_wait = wn;
    for (int i = 0; i < MAXB; i++) dev_rd[i] = 8'($urandom);
    for (int i = 0; i < MAXB; i++) req_wdata[8*i +: 8] = 8'($urandom);
    clear_mon();
    issue(rd, len, addr);
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    check(done === 1'b1, "R10", "done seen", done, 1);
    e = err; rdat = rsp_rdata;
    @(negedge clk);
    check(done === 1'b0, "R10", "done one cycle", done, 0);
    check(e === exp_to, "R7", "error flag", e, exp_to);
    check(spi_cs_n === 1'b1, "R4", "cs released at end", spi_cs_n, 1);
    check(ncsf == (exp_wake ? 2 : 1), "R9", "cs falls", ncsf, exp_wake ? 2 : 1);
    if (exp_wake)
      check(seg_low[0] == WLO && seg_gap[1] == WGAP, "R9", "wake low/gap",
            {seg_low[0][15:0], seg_gap[1][15:0]}, {16'(WLO), 16'(WGAP)});
    check(bad_sclk == 0, "R11", "sclk while deselected", bad_sclk, 0);
    check(busy_ready == 0, "R10", "ready while busy", busy_ready, 0);
    if (exp_to) begin
      check(rdat == '0, "R7", "zeroed read data", rdat[63:0], 0);
      check(nbits % 8 == 0 && nbits / 8 > 4, "R7", "whole poll bytes", nbits, 0);
    end else begin
      check(got[0] == exp_ctrl(rd, len), "R1", "control byte", got[0], exp_ctrl(rd, len));
      check({got[1], got[2], got[3]} == addr, "R2", "address bytes",
            {got[1], got[2], got[3]}, addr);
      check(nbits == 8 * (4 + wn + len), wn == 0 ? "R5" : "R4", "bits clocked",
            nbits, 8 * (4 + wn + len));
      for (int i = 0; i < wn; i++) if (got[4 + i] != 8'h00) bad++;
      if (wn > 0) check(bad == 0, "R6", "dummy poll bytes", bad, 0);
      bad = 0;
      if (rd) begin
        for (int i = 0; i < len; i++) if (rdat[8*i +: 8] != dev_rd[i]) bad++;
        check(bad == 0, "R8", "read bytes mismatches", bad, 0);
      end else begin
        for (int i = 0; i < len; i++) if (got[4 + wn + i] != req_wdata[8*i +: 8]) bad++;
        check(bad == 0, "R8", "write bytes mismatches", bad, 0);
      end
    end
  endtask

  task automatic reject(input int len);
    clear_mon();
    issue(1'b0, len, 24'h000000);
    // issue returns at the negedge after acceptance: result is registered
    check(done === 1'b1 && err === 1'b1, "R3", "reject done+err", {done, err}, 2'b11);
    check(spi_cs_n === 1'b1 && ncsf == 0, "R3", "cs untouched", ncsf, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C3A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R11", "reset bus state",
          {spi_cs_n, spi_sclk}, 2'b10);
    check(req_ready === 1'b1 && done === 1'b0, "R10", "reset handshake",
          {req_ready, done}, 2'b10);
    reject(0);
    reject(MAXB + 1);
    run(1'b0, 1,  24'hD40018, 0, 1'b1, 1'b0);
    run(1'b1, 4,  24'hD40F00, 0, 1'b0, 1'b0);
    run(1'b0, 64, 24'hA5C33C, 2, 1'b0, 1'b0);
    run(1'b1, 64, 24'h123456, 3, 1'b0, 1'b0);
    run(1'b1, 8,  24'h000024, 100000, 1'b0, 1'b1);
    repeat (IDLE + 500) @(negedge clk);
    run(1'b0, 3,  24'hFFFFFF, 1, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++)
      run(1'($urandom), int'($urandom_range(1, MAXB)), 24'($urandom),
          int'($urandom_range(0, 4)), 1'b0, 1'b0);
    repeat (IDLE + 500) @(negedge clk);
    run(1'b1, int'($urandom_range(1, MAXB)), 24'($urandom), 0, 1'b1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule